// File: doc/BRIEF.md
# Burst Address and Cycle Decoder

This block is the clocked front end of a synchronous burst SRAM. On every rising clock edge it samples two active-low address strobes (a processor-side strobe and a controller-side strobe), an active-low advance input, three chip enables, the write controls and an external address. From these it classifies the cycle as one of the following:

- deselect
- burst start (read or write) at the external address
- continue, which steps to the next burst address
- suspend, which holds the current address

It reports the resulting access on registered outputs. Outputs change only at the clock edge that samples the inputs. The internal address, the valid flag, the write flag and the per-byte write enables for the cycle sampled at edge k are visible from edge k until edge k+1.

The block owns a 2-bit burst counter. The upper address bits are loaded when a burst starts and do not change during the burst. The two low bits come from the loaded value combined with a step count. Linear order adds the step count modulo 4. Interleaved order XORs the step count into the loaded value. The order is picked by an input that is latched when the burst starts. Continue and suspend cycles are honoured only while a burst is active. After a deselect the block stays idle until the next strobe cycle starts a new burst.

Top module: `burst_addr_decoder`

## Requirements
- R1: A cycle with `cpu_strobe_n`=0 and `ce1_n`=0, with `ce2`=1 and `ce3_n`=0, starts a read burst at `addr_in`. `cyc_write` is 0 and `byte_we` is all zero whatever `gw_n`, `bw_n` and `byte_en_n` are.
- R2: While `ce1_n`=1, `cpu_strobe_n` has no effect. The cycle then behaves as continue, suspend or idle according to the other inputs.
- R3: A cycle with `ctl_strobe_n`=0 and `ce1_n`=0, and with `cpu_strobe_n`=1, starts a burst at `addr_in` when `ce2`=1 and `ce3_n`=0. It is a read or a write according to the write decode of R9.
- R4: A strobe cycle whose enables are not all true gives `cyc_valid`=0, `cyc_write`=0 and `byte_we`=0 after the edge. The enables are true when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A `ctl_strobe_n`=0 cycle with `ce1_n`=1 is always such a deselect.
- R5: During an active burst, a cycle with both strobes high (or with `cpu_strobe_n` masked by R2) and `adv_n`=0 steps to the next burst address. `ce2` and `ce3_n` are ignored. The read/write flags follow the write decode.
- R6: During an active burst, a cycle with both strobes high and `adv_n`=1 keeps `addr_out` unchanged. The read/write flags follow the write decode.
- R7: For a loaded low pair b and step count n: linear order gives `addr_out[1:0]` = (b+n) mod 4, and interleaved order gives b XOR n. The fifth address of a burst (n=4) equals b.
- R8: `order_sel` is sampled only on burst-start cycles (0 = linear, 1 = interleaved). Changing it during a burst does not change the sequence. Tie it high for the interleaved default.
- R9: Write decode: `gw_n`=0 sets every bit of `byte_we`. Otherwise `bw_n`=0 sets `byte_we[i]` = ~`byte_en_n[i]`. Otherwise `byte_we` is 0. `cyc_write` is 1 exactly when at least one byte is written.
- R10: `addr_out[ADDR_W-1:2]` holds the value loaded at burst start for the whole burst, whatever `addr_in` does.
- R11: While idle, continue and suspend cycles leave `cyc_valid` at 0.
- R12: After reset, `addr_out`=0, `cyc_valid`=0, `cyc_write`=0 and `byte_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low, masks the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high, sampled on strobe cycles only |
| ce3_n | input | 1 | Chip enable 3, active low, sampled on strobe cycles only |
| gw_n | input | 1 | Write all bytes, active low |
| bw_n | input | 1 | Byte-write qualifier, active low |
| byte_en_n | input | BYTES | Per-byte write enables, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current internal address |
| cyc_valid | output | 1 | Cycle is an active access |
| cyc_write | output | 1 | Active access is a write |
| byte_we | output | BYTES | Per-byte write enables of the current cycle |

## Verification
A wrong step count or a wrong latched order bit shows on `addr_out[1:0]` one edge after the continue cycle that used it. It keeps showing on every later address of that burst, so a sweep over all four start values in both orders, running past the wrap, exposes it within five cycles. A lost or stuck active flag shows as `cyc_valid` high after a deselect, or low after a start, in the very next cycle. A wrong upper-bit register shows when `addr_in` is changed during continue cycles. The bench keeps a cycle model built from the requirements and compares every output after every edge over directed sweeps and a long pseudo-random run.

// File: rtl/burst_dec_pkg.sv
`timescale 1ns/1ps
package burst_dec_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_DESELECT = 3'd1,
    CYC_LOAD_RD  = 3'd2,
    CYC_LOAD_CTL = 3'd3,
    CYC_CONTINUE = 3'd4,
    CYC_SUSPEND  = 3'd5
  } cyc_kind_e;

  localparam int unsigned LSB_W = 2;
endpackage

// File: rtl/bdec_classify.sv
`timescale 1ns/1ps
module bdec_classify
  import burst_dec_pkg::*;
(
  input  logic      cpu_strobe_n,
  input  logic      ctl_strobe_n,
  input  logic      adv_n,
  input  logic      ce1_n,
  input  logic      ce2,
  input  logic      ce3_n,
  input  logic      active,
  output cyc_kind_e kind
);
  logic cpu_hit;
  logic sub_en;

  assign cpu_hit = !cpu_strobe_n && !ce1_n;
  assign sub_en  = ce2 && !ce3_n;

  always_comb begin
    if (cpu_hit) begin
      kind = sub_en ? CYC_LOAD_RD : CYC_DESELECT;
    end else if (!ctl_strobe_n) begin
      kind = (!ce1_n && sub_en) ? CYC_LOAD_CTL : CYC_DESELECT;
    end else if (!active) begin
      kind = CYC_IDLE;
    end else begin
      kind = adv_n ? CYC_SUSPEND : CYC_CONTINUE;
    end
  end
endmodule

// File: rtl/bdec_wdecode.sv
`timescale 1ns/1ps
module bdec_wdecode #(
  parameter int unsigned BYTES = 2
) (
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [BYTES-1:0] byte_en_n,
  output logic [BYTES-1:0] we,
  output logic             is_write
);
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign we[i] = !gw_n || (!bw_n && !byte_en_n[i]);
  end

  assign is_write = |we;
endmodule

// File: rtl/bdec_counter.sv
`timescale 1ns/1ps
module bdec_counter
  import burst_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [LSB_W-1:0] base_in,
  input  logic             mode_in,
  output logic [LSB_W-1:0] lsb
);
  logic [LSB_W-1:0] base_q, base_d;
  logic [LSB_W-1:0] cnt_q, cnt_d;
  logic             mode_q, mode_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (load) begin
      base_d = base_in;
      cnt_d  = '0;
      mode_d = mode_in;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (load || step) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign lsb = mode_q ? (base_q ^ cnt_q) : (base_q + cnt_q);

  AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lsb == $past(base_in)));  // R7
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !mode_q) |=> (lsb == $past(lsb) + 2'd1));  // R7
  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode_q) |=> (lsb != $past(lsb)));  // R7
endmodule

// File: rtl/burst_addr_decoder.sv
`timescale 1ns/1ps
module burst_addr_decoder
  import burst_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              adv_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              bw_n,
  input  logic [BYTES-1:0]  byte_en_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              cyc_valid,
  output logic              cyc_write,
  output logic [BYTES-1:0]  byte_we
);
  localparam int unsigned UP_W = ADDR_W - LSB_W;

  cyc_kind_e        kind;
  logic [BYTES-1:0] dec_we;
  logic             dec_wr;
  logic [LSB_W-1:0] lsb;

  logic             active_q, active_d;
  logic             write_q,  write_d;
  logic [BYTES-1:0] we_q,     we_d;
  logic [UP_W-1:0]  upper_q,  upper_d;
  logic             do_load;

  bdec_classify u_classify (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .adv_n        (adv_n),
    .ce1_n        (ce1_n),
    .ce2          (ce2),
    .ce3_n        (ce3_n),
    .active       (active_q),
    .kind         (kind)
  );

  bdec_wdecode #(.BYTES(BYTES)) u_wdecode (
    .gw_n      (gw_n),
    .bw_n      (bw_n),
    .byte_en_n (byte_en_n),
    .we        (dec_we),
    .is_write  (dec_wr)
  );

  assign do_load = (kind == CYC_LOAD_RD) || (kind == CYC_LOAD_CTL);

  bdec_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (do_load),
    .step    (kind == CYC_CONTINUE),
    .base_in (addr_in[LSB_W-1:0]),
    .mode_in (order_sel),
    .lsb     (lsb)
  );

  always_comb begin
    active_d = active_q;
    write_d  = 1'b0;
    we_d     = '0;
    upper_d  = upper_q;
    unique case (kind)
      CYC_LOAD_RD: begin
        active_d = 1'b1;
        upper_d  = addr_in[ADDR_W-1:LSB_W];
      end
      CYC_LOAD_CTL: begin
        active_d = 1'b1;
        upper_d  = addr_in[ADDR_W-1:LSB_W];
        write_d  = dec_wr;
        we_d     = dec_we;
      end
      CYC_CONTINUE, CYC_SUSPEND: begin
        write_d  = dec_wr;
        we_d     = dec_we;
      end
      CYC_DESELECT: active_d = 1'b0;
      default: active_d = active_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
      we_q     <= '0;
      upper_q  <= '0;
    end else begin
      active_q <= active_d;
      write_q  <= write_d;
      we_q     <= we_d;
      if (do_load) begin
        upper_q <= upper_d;
      end
    end
  end

  assign addr_out  = {upper_q, lsb};
  assign cyc_valid = active_q;
  assign cyc_write = write_q;
  assign byte_we   = we_q;

  AST_CPU_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !ce1_n) |=> (!cyc_write && byte_we == '0));  // R1
  AST_CTL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && ce1_n) |=> (!cyc_valid && byte_we == '0));  // R4
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cpu_strobe_n && ctl_strobe_n && adv_n) |=> (cyc_valid && $stable(addr_out)));  // R6
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cpu_strobe_n && ctl_strobe_n) |=> $stable(addr_out[ADDR_W-1:LSB_W]));  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid && ctl_strobe_n && (cpu_strobe_n || ce1_n)) |=> !cyc_valid);  // R11
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_write |-> (byte_we == '0));  // R9
endmodule

// File: tb/burst_addr_decoder_test.sv
`timescale 1ns/1ps
module burst_addr_decoder_test;
  localparam int AW = 8;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_n, ctl_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bw_n, osel;
  logic [NB-1:0] ben_n;
  logic [AW-1:0] ain;
  logic [AW-1:0] addr_out;
  logic          cyc_valid, cyc_write;
  logic [NB-1:0] byte_we;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic          m_active, m_write, m_mode;
  logic [NB-1:0] m_we;
  logic [AW-3:0] m_upper;
  logic [1:0]    m_base, m_cnt;
  logic [15:0]   lfsr;

  always #2.5 clk = ~clk;

  burst_addr_decoder #(.ADDR_W(AW), .BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_n), .ctl_strobe_n(ctl_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bw_n(bw_n), .byte_en_n(ben_n), .order_sel(osel), .addr_in(ain),
    .addr_out(addr_out), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .byte_we(byte_we)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] l;
    l = m_mode ? (m_base ^ m_cnt) : (m_base + m_cnt);
    return {m_upper, l};
  endfunction

  task automatic check(string tag);
    logic [AW+NB+1:0] act, exp;
    act = {addr_out, cyc_valid, cyc_write, byte_we};
    exp = {exp_addr(), m_active, m_write, m_active ? m_we : {NB{1'b0}}};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {addr,valid,write,we} actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    cpu_n = 1; ctl_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bw_n = 1; ben_n = '1; osel = 0; ain = '0;
  endtask

  // One clock: update model from the requirements, then compare after the edge.
  task automatic step(string forced);
    logic [NB-1:0] dwe;
    string tag;
    dwe = !gw_n ? {NB{1'b1}} : (!bw_n ? ~ben_n : {NB{1'b0}});
    if (!cpu_n && !ce1_n) begin
      if (ce2 && !ce3_n) begin
        m_active = 1; m_write = 0; m_we = '0; m_upper = ain[AW-1:2];
        m_base = ain[1:0]; m_cnt = 0; m_mode = osel; tag = "R1";
      end else begin
        m_active = 0; m_write = 0; m_we = '0; tag = "R4";
      end
    end else if (!ctl_n) begin
      if (!ce1_n && ce2 && !ce3_n) begin
        m_active = 1; m_write = |dwe; m_we = dwe; m_upper = ain[AW-1:2];
        m_base = ain[1:0]; m_cnt = 0; m_mode = osel; tag = (|dwe) ? "R9" : "R3";
      end else begin
        m_active = 0; m_write = 0; m_we = '0; tag = "R4";
      end
    end else if (!m_active) begin
      m_write = 0; m_we = '0; tag = !cpu_n ? "R2" : "R11";
    end else begin
      m_write = |dwe; m_we = dwe;
      if (!adv_n) begin m_cnt = m_cnt + 1; tag = !cpu_n ? "R2" : "R5"; end
      else tag = "R6";
    end
    @(posedge clk);
    #1;
    check(forced != "" ? forced : tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    m_active = 0; m_write = 0; m_we = '0; m_upper = '0; m_base = 0; m_cnt = 0; m_mode = 0;
    #12;
    check("R12");
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;

    // R7 / R10: both orders, all four starts, run past the wrap with addr_in moving
    for (int md = 0; md < 2; md++) begin
      for (int b = 0; b < 4; b++) begin
        quiet(); ctl_n = 0; osel = md[0]; ain = 8'hA0 | 8'(b);
        step("R3");
        for (int k = 0; k < 5; k++) begin
          quiet(); adv_n = 0; ain = 8'h5C ^ 8'(k * 37); osel = ~md[0];
          step(k == 4 ? "R7" : (k == 2 ? "R10" : "R8"));
        end
      end
    end

    // R9: all write-control combinations on controller starts and on suspends
    for (int w = 0; w < 16; w++) begin
      quiet(); ctl_n = 0; ain = 8'(w * 13);
      gw_n = w[3]; bw_n = w[2]; ben_n = w[1:0];
      step("R9");
      quiet(); gw_n = w[3]; bw_n = w[2]; ben_n = w[1:0];
      step("R9");
    end

    // R1 / R2 / R4 / R5: strobes and enables, write controls asserted
    for (int s = 0; s < 64; s++) begin
      quiet(); ctl_n = 0; ain = 8'h33;
      step("");
      quiet();
      cpu_n = s[0]; ctl_n = s[1]; ce1_n = s[2]; ce2 = s[3]; ce3_n = s[4];
      adv_n = s[5]; gw_n = 0; ain = 8'(s * 7);
      step("");
      quiet(); adv_n = 0; ce2 = 0; ce3_n = 1;
      step("");
    end

    // R11: deselect, then continue and suspend cycles while idle
    quiet(); ctl_n = 0; ce2 = 0;
    step("R4");
    for (int k = 0; k < 4; k++) begin
      quiet(); adv_n = k[0]; cpu_n = k[1]; ce1_n = k[1];
      step("R11");
    end

    // pseudo-random run against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_n = |lfsr[2:0];
      ctl_n = |lfsr[5:3];
      adv_n = lfsr[6];
      ce1_n = &lfsr[8:7];
      ce2   = |lfsr[10:9];
      ce3_n = &lfsr[12:11];
      gw_n  = |lfsr[14:13];
      bw_n  = lfsr[15];
      ben_n = lfsr[1:0];
      osel  = lfsr[9];
      ain   = lfsr[15:8] ^ lfsr[7:0];
      step("");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule